// File: doc/BRIEF.md
# Watchdog Timer with Prescaler

This block is a watchdog that counts ticks from its own free-running clock. That clock is separate from the processor clock, so the watchdog keeps counting while the core is halted in its low-power state. Its timeout divides into two fixed parts. The first is a terminal count, derived from the tick frequency so that one unprescaled period lasts about 18 ms. The second is an optional power-of-two prescaler that stretches the period by up to 128 times.

Software keeps the watchdog from expiring by pulsing a clear strobe. Entering the low-power state also restarts the count, and it sets the time-out flag as well. If neither strobe arrives in time, the block emits a one-cycle timeout pulse and drops the time-out flag. It then sends the pulse out either as a reset request (core awake) or as a wake request (core asleep). A configuration enable that is held low stops the watchdog completely.

A control state machine has three states. `WD_OFF`: the configuration enable is low and the count is held at zero. `WD_COUNT`: the watchdog is counting. `WD_EXPIRED`: the single cycle in which a timeout is reported. The transitions are as follows:
- `WD_OFF` to `WD_COUNT` when the enable is high.
- `WD_COUNT` to `WD_EXPIRED` on a terminal hit.
- `WD_EXPIRED` to `WD_COUNT` on the next cycle.
- Any state to `WD_OFF` when the enable drops.

Top module: `wdog_timer`

## Requirements
- R1: After reset, `to_flag` is 1 and `timeout_pulse`, `reset_req` and `wake_req` are 0.
- R2: With the prescaler not assigned, a timeout pulse appears TERM tick cycles after the edge that samples a restart strobe, where TERM = TICK_HZ*18/1000. The internal count never reaches TERM.
- R3: With `ps_assign`=1, the 3-bit field `ps_sel` = n selects a ratio of 2^n (1:1 up to 1:128), and the period becomes TERM*2^n cycles.
- R4: `clr_strobe` restarts both the counter and the prescaler. A strobe given partway through a period pushes the timeout to a full period after the strobe.
- R5: `sleep_strobe` restarts the count in the same way as `clr_strobe`, and `to_flag` reads 1 in the cycle after it.
- R6: `to_flag` reads 0 in the same cycle as the timeout pulse.
- R7: `timeout_pulse` lasts exactly one cycle. Counting continues without a strobe, and the next pulse follows one full period later.
- R8: During the pulse, `reset_req` is 1 if `core_asleep` is 0, and `wake_req` is 1 if `core_asleep` is 1. The two are never high together.
- R9: While `fuse_en` is 0, no timeout occurs. Once it returns to 1, a strobe again gives a full-period timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Independent watchdog tick clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fuse_en | input | 1 | Configuration enable, 1 = watchdog active |
| clr_strobe | input | 1 | Software clear, one cycle |
| sleep_strobe | input | 1 | Sleep-entry strobe, one cycle |
| core_asleep | input | 1 | Core is in its low-power state |
| ps_assign | input | 1 | Routes the prescaler to the watchdog |
| ps_sel | input | 3 | Prescaler ratio select, ratio = 2^ps_sel |
| timeout_pulse | output | 1 | One-cycle timeout indication |
| reset_req | output | 1 | Timeout while awake: device reset request |
| wake_req | output | 1 | Timeout while asleep: wake-up request |
| to_flag | output | 1 | Time-out status flag, cleared by a timeout |

## Verification
The bench builds the block with TICK_HZ = 1000, which gives a terminal count of 18 ticks. The unprescaled period is therefore 18 cycles and the longest prescaled period (1:128) is 2304 cycles. The bench can then measure every period exactly, cycle by cycle, including the largest ratio and two back-to-back periods, in a short run. With the prescaler width left at its default of 7, every ratio select value is reachable.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic [1:0] {
        WD_OFF     = 2'd0,
        WD_COUNT   = 2'd1,
        WD_EXPIRED = 2'd2
    } wd_state_e;

    // Terminal count for a period of ms milliseconds at hz ticks per second
    function automatic int unsigned term_ticks(input int unsigned hz, input int unsigned ms);
        return (hz * ms) / 1000;
    endfunction

endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
    parameter int PS_W  = 7,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             assigned,
    input  logic             restart,
    input  logic [SEL_W-1:0] sel,
    output logic             adv
);
    logic [PS_W-1:0] ps_q;
    logic [PS_W-1:0] mask;

    // Low sel bits of the prescale count must all be ones to advance
    for (genvar i = 0; i < PS_W; i++) begin : g_mask
        assign mask[i] = (i < int'(sel));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ps_q <= '0;
        else if (!run || !assigned || restart)
            ps_q <= '0;
        else
            ps_q <= ps_q + 1'b1;
    end

    always_comb begin
        if (!run)
            adv = 1'b0;
        else if (!assigned)
            adv = 1'b1;
        else
            adv = ((ps_q & mask) == mask);
    end

    // R4: a restart leaves the prescale count at zero
    assert_ps_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (ps_q == '0));

endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
    parameter int unsigned TERM  = 18,
    parameter int          CNT_W = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic adv,
    input  logic restart,
    output logic term_hit
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TERM - 1);

    logic [CNT_W-1:0] cnt_q;

    assign term_hit = run && adv && !restart && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run || restart)
            cnt_q <= '0;
        else if (adv)
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    // R2: the count stays below its terminal value
    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CNT_W'(TERM));

    // R9: no counting while stopped
    assert_held_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0));

endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
    import wdog_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fuse_en,
    input  logic term_hit,
    input  logic sleep_strobe,
    input  logic core_asleep,
    output logic run,
    output logic timeout_pulse,
    output logic reset_req,
    output logic wake_req,
    output logic to_flag
);
    wd_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_OFF:     state_d = fuse_en ? WD_COUNT : WD_OFF;
            WD_COUNT:   state_d = !fuse_en ? WD_OFF : (term_hit ? WD_EXPIRED : WD_COUNT);
            WD_EXPIRED: state_d = !fuse_en ? WD_OFF : (term_hit ? WD_EXPIRED : WD_COUNT);
            default:    state_d = WD_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= WD_OFF;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            to_flag <= 1'b1;
        else if (sleep_strobe)
            to_flag <= 1'b1;
        else if (term_hit)
            to_flag <= 1'b0;
    end

    always_comb begin
        run           = (state_q != WD_OFF);
        timeout_pulse = (state_q == WD_EXPIRED);
        reset_req     = timeout_pulse && !core_asleep;
        wake_req      = timeout_pulse && core_asleep;
    end

    assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_pulse |=> !timeout_pulse);

    assert_flag_low_on_trip_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_pulse && !$past(sleep_strobe)) |-> !to_flag);

    assert_sleep_sets_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_strobe |=> to_flag);

    assert_fuse_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !fuse_en |=> !timeout_pulse);

    assert_req_split_R8: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_pulse |-> (reset_req != wake_req));

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int unsigned TICK_HZ = 14222,
    parameter int          PS_W    = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fuse_en,
    input  logic       clr_strobe,
    input  logic       sleep_strobe,
    input  logic       core_asleep,
    input  logic       ps_assign,
    input  logic [2:0] ps_sel,
    output logic       timeout_pulse,
    output logic       reset_req,
    output logic       wake_req,
    output logic       to_flag
);
    localparam int unsigned TERM  = term_ticks(TICK_HZ, 18);
    localparam int          CNT_W = (TERM > 2) ? $clog2(TERM) : 1;

    logic run, adv, restart, term_hit;

    assign restart = clr_strobe | sleep_strobe;

    wdog_prescale #(.PS_W(PS_W), .SEL_W(3)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .assigned (ps_assign),
        .restart  (restart),
        .sel      (ps_sel),
        .adv      (adv)
    );

    wdog_count #(.TERM(TERM), .CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .adv      (adv),
        .restart  (restart),
        .term_hit (term_hit)
    );

    wdog_ctrl u_ctl (
        .clk           (clk),
        .rst_n         (rst_n),
        .fuse_en       (fuse_en),
        .term_hit      (term_hit),
        .sleep_strobe  (sleep_strobe),
        .core_asleep   (core_asleep),
        .run           (run),
        .timeout_pulse (timeout_pulse),
        .reset_req     (reset_req),
        .wake_req      (wake_req),
        .to_flag       (to_flag)
    );

    initial begin
        assert_term_legal_R2: assert (TERM >= 2);
    end

endmodule

// File: tb/wdog_timer_tb.sv
module wdog_timer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int TERM = 18;

    logic clk = 0;
    logic rst_n = 0;
    logic fuse_en = 1, clr_strobe = 0, sleep_strobe = 0, core_asleep = 0, ps_assign = 0;
    logic [2:0] ps_sel = 0;
    logic timeout_pulse, reset_req, wake_req, to_flag;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdog_timer #(.TICK_HZ(1000), .PS_W(7)) u_dut (
        .clk(clk), .rst_n(rst_n), .fuse_en(fuse_en), .clr_strobe(clr_strobe),
        .sleep_strobe(sleep_strobe), .core_asleep(core_asleep), .ps_assign(ps_assign),
        .ps_sel(ps_sel), .timeout_pulse(timeout_pulse), .reset_req(reset_req),
        .wake_req(wake_req), .to_flag(to_flag)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Strobe, then count edges until the timeout pulse is seen
    task automatic measure(input bit use_sleep, output int n);
        bit hit = 0;
        @(negedge clk);
        if (use_sleep) sleep_strobe = 1; else clr_strobe = 1;
        @(posedge clk);
        @(negedge clk);
        clr_strobe = 0;
        sleep_strobe = 0;
        if (use_sleep) check("R5 flag set by sleep", int'(to_flag), 1);
        n = 0;
        while (!hit && n < 5000) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (timeout_pulse) hit = 1;
        end
    endtask

    task automatic t_reset;
        check("R1 to_flag", int'(to_flag), 1);
        check("R1 timeout_pulse", int'(timeout_pulse), 0);
        check("R1 reqs", int'({reset_req, wake_req}), 0);
    endtask

    task automatic t_base_and_repeat;
        int n, m;
        bit hit;
        ps_assign = 0;
        measure(0, n);
        check("R2 unprescaled period", n, TERM);
        check("R6 flag cleared on timeout", int'(to_flag), 0);
        check("R8 awake gives reset_req", int'({reset_req, wake_req}), 2);
        m = 0; hit = 0;
        @(posedge clk); m++; @(negedge clk);
        check("R7 single-cycle pulse", int'(timeout_pulse), 0);
        while (!hit && m < 5000) begin
            @(posedge clk); m++; @(negedge clk);
            if (timeout_pulse) hit = 1;
        end
        check("R7 repeat period", m, TERM);
    endtask

    task automatic t_prescale(input int sel);
        int n;
        ps_assign = 1;
        ps_sel = 3'(sel);
        measure(0, n);
        check($sformatf("R3 period sel=%0d", sel), n, TERM * (1 << sel));
        ps_assign = 0;
        ps_sel = 0;
    endtask

    task automatic t_midway;
        int n, pulses = 0;
        ps_assign = 1;
        ps_sel = 2;
        @(negedge clk); clr_strobe = 1;
        @(negedge clk); clr_strobe = 0;
        repeat (50) begin
            @(negedge clk);
            if (timeout_pulse) pulses++;
        end
        check("R4 no pulse before period", pulses, 0);
        measure(0, n);
        check("R4 restart midway", n, TERM * 4);
        ps_assign = 0;
        ps_sel = 0;
    endtask

    task automatic t_sleep;
        int n;
        core_asleep = 1;
        measure(1, n);
        check("R5 sleep restart period", n, TERM);
        check("R8 asleep gives wake_req", int'({reset_req, wake_req}), 1);
        check("R6 flag cleared in sleep", int'(to_flag), 0);
        core_asleep = 0;
    endtask

    task automatic t_fuse;
        int n, pulses = 0;
        @(negedge clk); fuse_en = 0;
        repeat (3 * TERM) begin
            @(negedge clk);
            if (timeout_pulse) pulses++;
        end
        check("R9 no timeout while disabled", pulses, 0);
        @(negedge clk); fuse_en = 1;
        repeat (2) @(negedge clk);
        measure(0, n);
        check("R9 period after re-enable", n, TERM);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_base_and_repeat();
        t_prescale(0);
        t_prescale(3);
        t_prescale(7);
        t_midway();
        t_sleep();
        t_fuse();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule